// File: doc/BRIEF.md
# Adaptive Speed Reduction Controller

This block supervises the speed command of a variable-speed compressor drive. After reset it commands full speed. Once the leaving-water temperature error sits inside a narrow window around setpoint and the control loop reports itself stable, it lowers the command by one 0.1 Hz step per step tick. The inlet vanes open to compensate, and the controller stops lowering speed when the vanes reach full open, when the loop becomes unstable, or when the next step would cross a learned surge floor.

A surge-detect pulse raises the command by a fixed boost. The head and flow indices present at that moment select an entry of a small learned table, and the boosted speed becomes that entry's minimum-speed floor. The floor only ever rises, so later reductions under matching conditions stop at or above it. Every surge, automatic or manual, adds to a saturating surge total. When the vanes are held at full open and the load rises, the speed climbs one step per tick until the vanes close back to the resume position. A manual mode freezes the command.

The controller is a state machine with six named states. WAIT holds speed while the qualifying conditions are missing. REDUCE steps down on ticks. FLOOR holds at the learned or absolute minimum. OPEN holds at full-open vanes. RAISE steps up on ticks after a load increase at full-open vanes. MANUAL freezes the command. The transitions are:
- WAIT→OPEN and REDUCE→OPEN and FLOOR→OPEN on full vanes.
- WAIT→REDUCE on qualification.
- REDUCE→WAIT and FLOOR→WAIT on loss of qualification.
- REDUCE→FLOOR when no step remains.
- FLOOR→REDUCE when the active limit falls below the speed.
- OPEN→RAISE on a temperature error above the window.
- OPEN→WAIT when the vanes leave full open.
- RAISE→WAIT at the resume vane position.
- Any state to MANUAL while the manual flag is high, and MANUAL→WAIT when it drops.
- Any automatic state to WAIT on a surge.

Top module: `asrc_controller`

## Requirements
- R1: While reset is asserted and right after it, speed_cmd equals FULL_SPEED (600, i.e. 60.0 Hz), surge_count is 0, and surge_led and unstable_led are 0.
- R2: A step tick lowers speed only when temp_err is within -6..+3 inclusive (signed two's complement, units of 0.1 degree, error = actual minus setpoint) and stable is 1. Otherwise the tick leaves speed_cmd unchanged.
- R3: In reduction, each tick lowers speed_cmd by exactly 1 (0.1 Hz). Without a tick the command does not change, and the command never goes below MIN_SPEED (300).
- R4: While vane_pct is at or above 100 the command is never lowered, and the last speed reached is held.
- R5: In the full-open hold, a temp_err above +3 makes each tick raise speed_cmd by 1, capped at FULL_SPEED, while vane_pct is above 95. Once vane_pct is 95 or less, raising stops and reduction resumes when qualified.
- R6: A surge in automatic mode raises speed_cmd by SURGE_BOOST (20), capped at FULL_SPEED. It sets the floor of entry {head_idx, flow_idx} to the larger of its old value and the new speed. Reduction never takes speed_cmd below the floor of the current entry.
- R7: Each clock cycle with surge_pulse high adds 1 to surge_count one cycle later, in every mode including full speed and manual.
- R8: unstable_led equals the inverse of stable one cycle earlier, and no reduction step occurs while stable is 0.
- R9: surge_led goes to 1 the cycle after a surge and stays 1 until the next reduction step.
- R10: While manual_mode is 1, speed_cmd holds its value: no reduction, no raise and no surge boost. Surges are still counted and recorded in the floor table at the held speed.
- R11: surge_count saturates at 2**CNT_W-1 (255) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Step tick, one cycle per permitted step |
| temp_err | input | 8 | Signed leaving-water error, 0.1 degree units |
| stable | input | 1 | Loop stability flag |
| vane_pct | input | 7 | Vane opening in percent |
| surge_pulse | input | 1 | Surge detected, one pulse per event |
| head_idx | input | 2 | Quantized head index |
| flow_idx | input | 2 | Quantized flow index |
| manual_mode | input | 1 | Manual speed hold |
| speed_cmd | output | 12 | Speed command, 0.1 Hz units |
| unstable_led | output | 1 | Instability indicator |
| surge_led | output | 1 | Surge indicator |
| surge_count | output | 8 | Saturating surge total |

## Verification
The bench probes both edges of the temperature window: +3 and -6 must qualify, while +4 and -7 must not. A design with an off-by-one or unsigned compare would step or stall at the wrong error. It builds a surge floor, leaves the matching entry to step below it, and returns from a higher speed to confirm reduction stops exactly at the floor. It then surges again at a lower speed and rises above that point, so a table that overwrote the floor instead of keeping the maximum would step below the earlier surge point. The remaining tests cover four cases:
- The full-open raise and its 95 % release: a wrong threshold keeps climbing or stops early.
- The manual freeze with surges still counted.
- The capped boost at full speed.
- The counter at saturation: a wrapping counter would read back a small value.

// File: rtl/asrc_pkg.sv
package asrc_pkg;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_REDUCE = 3'd1,
        ST_FLOOR  = 3'd2,
        ST_OPEN   = 3'd3,
        ST_RAISE  = 3'd4,
        ST_MANUAL = 3'd5
    } asrc_state_e;

endpackage

// File: rtl/asrc_qualify.sv
module asrc_qualify #(
    parameter int TERR_W      = 8,
    parameter int VANE_W      = 7,
    parameter int WIN_HI      = 3,
    parameter int WIN_LO      = -6,
    parameter int VANE_FULL   = 100,
    parameter int VANE_RESUME = 95
) (
    input  logic signed [TERR_W-1:0] temp_err,
    input  logic                     stable,
    input  logic        [VANE_W-1:0] vane_pct,
    output logic                     reduce_ok,
    output logic                     vane_full,
    output logic                     vane_back,
    output logic                     load_rise
);
    localparam logic signed [TERR_W-1:0] HI_V = TERR_W'(WIN_HI);
    localparam logic signed [TERR_W-1:0] LO_V = TERR_W'(WIN_LO);
    localparam logic [VANE_W-1:0] FULL_V   = VANE_W'(VANE_FULL);
    localparam logic [VANE_W-1:0] RESUME_V = VANE_W'(VANE_RESUME);

    logic in_window;

    always_comb begin
        in_window = (temp_err <= HI_V) && (temp_err >= LO_V);
        reduce_ok = in_window && stable;
        vane_full = (vane_pct >= FULL_V);
        vane_back = (vane_pct <= RESUME_V);
        load_rise = (temp_err > HI_V);
    end
endmodule

// File: rtl/asrc_surge_map.sv
module asrc_surge_map #(
    parameter int HEAD_W = 2,
    parameter int FLOW_W = 2,
    parameter int SPD_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [HEAD_W+FLOW_W-1:0] idx,
    input  logic [SPD_W-1:0]         wr_speed,
    output logic [SPD_W-1:0]         rd_floor
);
    localparam int IDX_W   = HEAD_W + FLOW_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [SPD_W-1:0] floor_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                floor_q[g] <= '0;
            end else if (wr_en && (idx == IDX_W'(g)) && (wr_speed > floor_q[g])) begin
                floor_q[g] <= wr_speed;
            end
        end
    end

    assign rd_floor = floor_q[idx];
endmodule

// File: rtl/asrc_surge_counter.sv
module asrc_surge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (hit && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/asrc_fsm.sv
module asrc_fsm
    import asrc_pkg::*;
#(
    parameter int SPD_W       = 12,
    parameter int FULL_SPEED  = 600,
    parameter int MIN_SPEED   = 300,
    parameter int SURGE_BOOST = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             surge_pulse,
    input  logic             manual_mode,
    input  logic             stable,
    input  logic             reduce_ok,
    input  logic             vane_full,
    input  logic             vane_back,
    input  logic             load_rise,
    input  logic [SPD_W-1:0] floor_rd,
    output logic [SPD_W-1:0] map_wdata,
    output logic [SPD_W-1:0] speed_cmd,
    output logic             unstable_led,
    output logic             surge_led
);
    localparam logic [SPD_W-1:0] FULL_V  = SPD_W'(FULL_SPEED);
    localparam logic [SPD_W-1:0] MIN_V   = SPD_W'(MIN_SPEED);
    localparam logic [SPD_W-1:0] BOOST_V = SPD_W'(SURGE_BOOST);
    localparam logic [SPD_W-1:0] KNEE_V  = SPD_W'(FULL_SPEED - SURGE_BOOST);

    asrc_state_e      state_q, state_d;
    logic [SPD_W-1:0] speed_q, speed_d;
    logic [SPD_W-1:0] boosted, limit;
    logic             above_limit, step_down;
    logic             surge_led_q, unstable_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // limits shared by transitions and outputs
    always_comb begin
        boosted     = (speed_q >= KNEE_V) ? FULL_V : (speed_q + BOOST_V);
        limit       = (floor_rd > MIN_V) ? floor_rd : MIN_V;
        above_limit = (speed_q > limit);
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (manual_mode) begin
            state_d = ST_MANUAL;
        end else if (surge_pulse) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (vane_full)      state_d = ST_OPEN;
                    else if (reduce_ok) state_d = ST_REDUCE;
                end
                ST_REDUCE: begin
                    if (vane_full)         state_d = ST_OPEN;
                    else if (!reduce_ok)   state_d = ST_WAIT;
                    else if (!above_limit) state_d = ST_FLOOR;
                end
                ST_FLOOR: begin
                    if (vane_full)        state_d = ST_OPEN;
                    else if (!reduce_ok)  state_d = ST_WAIT;
                    else if (above_limit) state_d = ST_REDUCE;
                end
                ST_OPEN: begin
                    if (load_rise)       state_d = ST_RAISE;
                    else if (!vane_full) state_d = ST_WAIT;
                end
                ST_RAISE: begin
                    if (vane_back) state_d = ST_WAIT;
                end
                ST_MANUAL: begin
                    state_d = ST_WAIT;
                end
                default: state_d = ST_WAIT;
            endcase
        end
    end

    // outputs and speed datapath
    always_comb begin
        speed_d   = speed_q;
        step_down = 1'b0;
        map_wdata = manual_mode ? speed_q : boosted;
        if (!manual_mode) begin
            if (surge_pulse) begin
                speed_d = boosted;
            end else begin
                unique case (state_q)
                    ST_REDUCE: begin
                        if (tick && reduce_ok && !vane_full && above_limit) begin
                            speed_d   = speed_q - 1'b1;
                            step_down = 1'b1;
                        end
                    end
                    ST_RAISE: begin
                        if (tick && !vane_back && (speed_q < FULL_V)) begin
                            speed_d = speed_q + 1'b1;
                        end
                    end
                    default: speed_d = speed_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_q     <= FULL_V;
            surge_led_q <= 1'b0;
            unstable_q  <= 1'b0;
        end else begin
            speed_q    <= speed_d;
            unstable_q <= !stable;
            if (surge_pulse)    surge_led_q <= 1'b1;
            else if (step_down) surge_led_q <= 1'b0;
        end
    end

    assign speed_cmd    = speed_q;
    assign surge_led    = surge_led_q;
    assign unstable_led = unstable_q;
endmodule

// File: rtl/asrc_controller.sv
module asrc_controller #(
    parameter int SPD_W       = 12,
    parameter int FULL_SPEED  = 600,
    parameter int MIN_SPEED   = 300,
    parameter int SURGE_BOOST = 20,
    parameter int HEAD_W      = 2,
    parameter int FLOW_W      = 2,
    parameter int TERR_W      = 8,
    parameter int WIN_HI      = 3,
    parameter int WIN_LO      = -6,
    parameter int VANE_W      = 7,
    parameter int VANE_FULL   = 100,
    parameter int VANE_RESUME = 95,
    parameter int CNT_W       = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic signed [TERR_W-1:0] temp_err,
    input  logic                     stable,
    input  logic        [VANE_W-1:0] vane_pct,
    input  logic                     surge_pulse,
    input  logic        [HEAD_W-1:0] head_idx,
    input  logic        [FLOW_W-1:0] flow_idx,
    input  logic                     manual_mode,
    output logic        [SPD_W-1:0]  speed_cmd,
    output logic                     unstable_led,
    output logic                     surge_led,
    output logic        [CNT_W-1:0]  surge_count
);
    localparam int IDX_W = HEAD_W + FLOW_W;

    logic             reduce_ok, vane_full, vane_back, load_rise;
    logic [SPD_W-1:0] floor_rd, map_wdata;
    logic [IDX_W-1:0] map_idx;

    assign map_idx = {head_idx, flow_idx};

    asrc_qualify #(
        .TERR_W(TERR_W), .VANE_W(VANE_W), .WIN_HI(WIN_HI), .WIN_LO(WIN_LO),
        .VANE_FULL(VANE_FULL), .VANE_RESUME(VANE_RESUME)
    ) u_qualify (
        .temp_err(temp_err), .stable(stable), .vane_pct(vane_pct),
        .reduce_ok(reduce_ok), .vane_full(vane_full),
        .vane_back(vane_back), .load_rise(load_rise)
    );

    asrc_surge_map #(.HEAD_W(HEAD_W), .FLOW_W(FLOW_W), .SPD_W(SPD_W)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(surge_pulse), .idx(map_idx),
        .wr_speed(map_wdata), .rd_floor(floor_rd)
    );

    asrc_surge_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .hit(surge_pulse), .count(surge_count)
    );

    asrc_fsm #(
        .SPD_W(SPD_W), .FULL_SPEED(FULL_SPEED), .MIN_SPEED(MIN_SPEED),
        .SURGE_BOOST(SURGE_BOOST)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .surge_pulse(surge_pulse),
        .manual_mode(manual_mode), .stable(stable), .reduce_ok(reduce_ok),
        .vane_full(vane_full), .vane_back(vane_back), .load_rise(load_rise),
        .floor_rd(floor_rd), .map_wdata(map_wdata), .speed_cmd(speed_cmd),
        .unstable_led(unstable_led), .surge_led(surge_led)
    );
endmodule

// File: rtl/asrc_checker.sv
module asrc_checker #(
    parameter int SPD_W      = 12,
    parameter int FULL_SPEED = 600,
    parameter int MIN_SPEED  = 300,
    parameter int VANE_W     = 7,
    parameter int VANE_FULL  = 100,
    parameter int CNT_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              stable,
    input logic              surge_pulse,
    input logic              manual_mode,
    input logic [VANE_W-1:0] vane_pct,
    input logic [SPD_W-1:0]  speed_cmd,
    input logic              unstable_led,
    input logic              surge_led,
    input logic [CNT_W-1:0]  surge_count
);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [SPD_W-1:0]  FULL_V  = SPD_W'(FULL_SPEED);
    localparam logic [SPD_W-1:0]  MIN_V   = SPD_W'(MIN_SPEED);
    localparam logic [VANE_W-1:0] VFULL_V = VANE_W'(VANE_FULL);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_cmd >= MIN_V) && (speed_cmd <= FULL_V));

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (speed_cmd < $past(speed_cmd)) |->
            ($past(tick) && (($past(speed_cmd) - speed_cmd) == SPD_W'(1))));

    p_unstable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(stable) |-> (speed_cmd >= $past(speed_cmd)));

    p_open_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(vane_pct) >= VFULL_V) |-> (speed_cmd >= $past(speed_cmd)));

    p_count_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(surge_pulse) && ($past(surge_count) != CNT_MAX) |->
            (surge_count == $past(surge_count) + 1'b1));

    p_led_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (unstable_led == !$past(stable)));

    p_surge_led_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(surge_pulse) |-> surge_led);

    p_manual_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(manual_mode) |-> $stable(speed_cmd));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(surge_count) == CNT_MAX) |-> (surge_count == CNT_MAX));
endmodule

bind asrc_controller asrc_checker #(
    .SPD_W(SPD_W), .FULL_SPEED(FULL_SPEED), .MIN_SPEED(MIN_SPEED),
    .VANE_W(VANE_W), .VANE_FULL(VANE_FULL), .CNT_W(CNT_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stable(stable),
    .surge_pulse(surge_pulse), .manual_mode(manual_mode), .vane_pct(vane_pct),
    .speed_cmd(speed_cmd), .unstable_led(unstable_led), .surge_led(surge_led),
    .surge_count(surge_count)
);

// File: tb/tb_asrc_controller.sv
module tb_asrc_controller;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic signed [7:0] temp_err = '0;
    logic              stable = 1'b1;
    logic [6:0]        vane_pct = 7'd50;
    logic              surge_pulse = 1'b0;
    logic [1:0]        head_idx = '0;
    logic [1:0]        flow_idx = '0;
    logic              manual_mode = 1'b0;
    logic [11:0]       speed_cmd;
    logic              unstable_led, surge_led;
    logic [7:0]        surge_count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asrc_controller dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .temp_err(temp_err),
        .stable(stable), .vane_pct(vane_pct), .surge_pulse(surge_pulse),
        .head_idx(head_idx), .flow_idx(flow_idx), .manual_mode(manual_mode),
        .speed_cmd(speed_cmd), .unstable_led(unstable_led),
        .surge_led(surge_led), .surge_count(surge_count)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic surge_once();
        @(negedge clk) surge_pulse = 1'b1;
        @(negedge clk) surge_pulse = 1'b0;
    endtask

    task automatic set_idx(input int h, input int f);
        head_idx = 2'(h);
        flow_idx = 2'(f);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        settle(3);
        check_eq("R1 speed in reset", speed_cmd, 600);
        check_eq("R1 count in reset", surge_count, 0);
        check_eq("R1 surge_led in reset", surge_led, 0);
        check_eq("R1 unstable_led in reset", unstable_led, 0);
        rst_n = 1'b1;
        settle(2);
        check_eq("R1 speed after reset", speed_cmd, 600);
    endtask

    task automatic test_window();
        temp_err = 8'sd4;  settle(2); ticks(3);
        check_eq("R2 +4 ignored", speed_cmd, 600);
        temp_err = -8'sd7; settle(2); ticks(3);
        check_eq("R2 -7 ignored", speed_cmd, 600);
        temp_err = 8'sd3;  settle(2); ticks(2);
        check_eq("R2 R3 +3 steps", speed_cmd, 598);
        temp_err = -8'sd6; settle(2); ticks(2);
        check_eq("R2 R3 -6 steps", speed_cmd, 596);
        temp_err = 8'sd0;  settle(4);
        check_eq("R3 no tick no change", speed_cmd, 596);
    endtask

    task automatic test_unstable();
        stable = 1'b0; settle(1);
        check_eq("R8 led lit", unstable_led, 1);
        ticks(3);
        check_eq("R8 no step while unstable", speed_cmd, 596);
        stable = 1'b1; settle(2);
        check_eq("R8 led clear", unstable_led, 0);
    endtask

    task automatic test_open_and_raise();
        vane_pct = 7'd100; settle(2); ticks(3);
        check_eq("R4 hold at full vanes", speed_cmd, 596);
        temp_err = 8'sd5; settle(2); ticks(2);
        check_eq("R5 raise on load", speed_cmd, 598);
        vane_pct = 7'd97; ticks(1);
        check_eq("R5 raise above 95", speed_cmd, 599);
        vane_pct = 7'd95; settle(2); ticks(2);
        check_eq("R5 stop at 95", speed_cmd, 599);
        temp_err = 8'sd0; settle(2); ticks(1);
        check_eq("R5 reduction resumes", speed_cmd, 598);
    endtask

    task automatic test_surge_floor();
        set_idx(1, 2); ticks(38);
        check_eq("R3 reduced to 560", speed_cmd, 560);
        surge_once();
        check_eq("R6 boost", speed_cmd, 580);
        check_eq("R7 count 1", surge_count, 1);
        check_eq("R9 surge led on", surge_led, 1);
        settle(3); ticks(3);
        check_eq("R6 floor blocks step", speed_cmd, 580);
        check_eq("R9 led held", surge_led, 1);
        set_idx(0, 0); settle(2); ticks(3);
        check_eq("R6 other entry free", speed_cmd, 577);
        check_eq("R9 led cleared on step", surge_led, 0);
        surge_once();
        check_eq("R6 second boost", speed_cmd, 597);
        set_idx(1, 2); settle(3); ticks(20);
        check_eq("R6 stops at floor", speed_cmd, 580);
        // floor of entry 0 must keep its larger value
        set_idx(3, 3); settle(3); ticks(10);
        check_eq("R3 free entry", speed_cmd, 570);
        set_idx(0, 0); settle(1);
        surge_once();
        check_eq("R6 boost from 570", speed_cmd, 590);
        check_eq("R7 count 3", surge_count, 3);
        set_idx(3, 3); vane_pct = 7'd100; temp_err = 8'sd5; settle(3); ticks(3);
        check_eq("R5 raise to 593", speed_cmd, 593);
        vane_pct = 7'd50; temp_err = 8'sd0; set_idx(0, 0); settle(3); ticks(3);
        check_eq("R6 floor kept maximum", speed_cmd, 593);
    endtask

    task automatic test_manual();
        manual_mode = 1'b1; set_idx(3, 3); settle(2); ticks(3);
        check_eq("R10 no step in manual", speed_cmd, 593);
        surge_once();
        check_eq("R10 no boost in manual", speed_cmd, 593);
        check_eq("R7 R10 counted in manual", surge_count, 4);
        vane_pct = 7'd100; temp_err = 8'sd5; settle(2); ticks(3);
        check_eq("R10 no raise in manual", speed_cmd, 593);
        for (int i = 0; i < 255; i++) surge_once();
        check_eq("R11 saturated", surge_count, 255);
        manual_mode = 1'b0; vane_pct = 7'd50; temp_err = 8'sd0; settle(2);
    endtask

    task automatic test_cap_and_min();
        rst_n = 1'b0; settle(2); set_idx(2, 2); rst_n = 1'b1; settle(2);
        check_eq("R1 count cleared", surge_count, 0);
        surge_once();
        check_eq("R6 boost capped", speed_cmd, 600);
        check_eq("R7 count at full speed", surge_count, 1);
        set_idx(3, 3); settle(3); ticks(305);
        check_eq("R3 min floor", speed_cmd, 300);
    endtask

    initial begin
        test_reset();
        test_window();
        test_unstable();
        test_open_and_raise();
        test_surge_floor();
        test_manual();
        test_cap_and_min();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule